// File: doc/BRIEF.md
# Grouped Priority Arbiter with Daisy-Chained Masters

This block hands a shared bus to one master at a time. The masters are split into priority groups. Each group presents one request line, which is the OR of its members' requests, to a central stage. The central stage looks at all group requests at once and picks the most important eligible group. That group's grant then ripples down the group's daisy chain, and the first master in the chain that is requesting takes it. A processor priority level blanks out the lower groups, so a processor running at a raised level is not interrupted by less urgent bus traffic.

A grant is offered only when the bus is idle. The offered master confirms ownership by asserting the bus-busy line. The grant is removed once that busy is seen. No new grant can be made until the owner drops busy again. If the offered master withdraws its request before taking the bus, the offer is cancelled.

The block reports which master won as a one-hot grant vector and as a group/position index pair. Chain length, group count and level width are parameters. A build option selects either a rippling chain or a lookahead chain, and both give the same result.

Top module: `grp_chain_arbiter`

## Requirements
- R1: While rst_n is low, grant_o is all zero, grant_valid_o is 0, and win_group_o and win_pos_o are 0, whatever the requests.
- R2: Among the eligible groups with at least one request, the one with the highest group number wins. Group 4 is the highest and group 0 the lowest.
- R3: Within the winning group, the requesting master with the lowest chain position wins. Position 0 is nearest the arbiter. Master p of group g is bit g*CHAIN_LEN+p of req_i and grant_o.
- R4: A group is eligible only if its number is strictly greater than cpu_level_i. Requests from groups at or below the level produce no grant. Group 0 is therefore never granted, and level 7 blocks every group.
- R5: A grant is issued only on a clock edge at which the arbiter is idle and bus_busy_i is low. While bus_busy_i is high with no offer outstanding, no grant appears.
- R6: An offered grant stays unchanged while bus_busy_i is low and the granted master keeps requesting. It is removed the cycle after bus_busy_i is seen high. After that, no new grant is issued until the edge following the first cycle with bus_busy_i low. Busy takes precedence over a request dropped in the same cycle.
- R7: If the granted master drops its request while bus_busy_i is still low, the grant is withdrawn on the next edge. Arbitration is then free again on the following edge.
- R8: grant_o has at most one bit set. grant_valid_o is high exactly when it has one bit set. While valid, win_group_o and win_pos_o give the group and position of the granted master, and both are 0 otherwise.
- R9: Any single member's request makes its group compete, including the member farthest down the chain. That member wins when it is the only requester in the highest eligible group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_GROUPS*CHAIN_LEN | Master requests, group-major, position 0 first |
| bus_busy_i | input | 1 | Asserted by the current bus owner while it holds the bus |
| cpu_level_i | input | LVL_W | Processor priority level; groups at or below it are masked |
| grant_o | output | NUM_GROUPS*CHAIN_LEN | One-hot grant to the offered master |
| grant_valid_o | output | 1 | A grant offer is outstanding |
| win_group_o | output | GRP_W | Group number of the offered master |
| win_pos_o | output | POS_W | Chain position of the offered master |

## Verification
The bench drives two situations where functions meet in one cycle. In the first, the offered master raises bus-busy in the same cycle that it drops its request. In the second, bus-busy falls while other masters are already waiting. Both are judged against a behavioural model in the bench, which is compared with the outputs every cycle. The model and explicit checks confirm that busy takes precedence, so the block must pass through ownership rather than withdraw the offer. They also confirm that the waiting master gets its grant exactly one edge after busy drops, and not at the edge where busy falls.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_OFFER = 2'd1,
      ARB_OWNED = 2'd2
   } arb_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/arb_daisy_chain.sv
module arb_daisy_chain #(
   parameter int LEN       = 4,
   parameter bit LOOKAHEAD = 1'b0
) (
   input  logic [LEN-1:0] req_i,
   input  logic           gin_i,
   output logic [LEN-1:0] gnt_o,
   output logic           greq_o
);

   assign greq_o = |req_i;

   generate
      if (LEN < 1) begin : g_bad_len
         $error("arb_daisy_chain: LEN must be at least 1");
      end

      if (LOOKAHEAD) begin : g_lookahead
         logic [LEN-1:0] first_req;
         assign first_req = req_i & (~req_i + LEN'(1));
         assign gnt_o     = gin_i ? first_req : '0;
      end else begin : g_ripple
         logic [LEN:0] pass;
         assign pass[0] = gin_i;
         for (genvar i = 0; i < LEN; i++) begin : g_stage
            assign gnt_o[i]  = pass[i] & req_i[i];
            assign pass[i+1] = pass[i] & ~req_i[i];
         end
      end
   endgenerate

endmodule

// File: rtl/arb_group_pick.sv
module arb_group_pick #(
   parameter int NG    = 5,
   parameter int LVL_W = 3
) (
   input  logic [NG-1:0]    greq_i,
   input  logic [LVL_W-1:0] level_i,
   output logic [NG-1:0]    ggnt_o,
   output logic             any_o
);

   logic [NG-1:0] elig;

   always_comb begin
      for (int g = 0; g < NG; g++) begin
         elig[g] = greq_i[g] && (g > int'(level_i));
      end
   end

   always_comb begin
      for (int g = 0; g < NG; g++) begin
         ggnt_o[g] = elig[g] && ((elig >> (g + 1)) == '0);
      end
   end

   assign any_o = |elig;

endmodule

// File: rtl/arb_onehot_enc.sv
module arb_onehot_enc #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] oh_i,
   output logic [W-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (oh_i[i]) idx_o = idx_o | W'(i);
      end
   end

endmodule

// File: rtl/grp_chain_arbiter.sv
module grp_chain_arbiter
   import arb_pkg::*;
#(
   parameter int NUM_GROUPS      = 5,
   parameter int CHAIN_LEN       = 4,
   parameter int LVL_W           = 3,
   parameter bit CHAIN_LOOKAHEAD = 1'b0,
   localparam int NUM_MASTERS    = NUM_GROUPS * CHAIN_LEN,
   localparam int GRP_W          = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int POS_W          = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req_i,
   input  logic                   bus_busy_i,
   input  logic [LVL_W-1:0]       cpu_level_i,
   output logic [NUM_MASTERS-1:0] grant_o,
   output logic                   grant_valid_o,
   output logic [GRP_W-1:0]       win_group_o,
   output logic [POS_W-1:0]       win_pos_o
);

   generate
      if (NUM_GROUPS < 2) begin : g_bad_groups
         $error("grp_chain_arbiter: NUM_GROUPS must be at least 2");
      end
      if (CHAIN_LEN < 1) begin : g_bad_chain
         $error("grp_chain_arbiter: CHAIN_LEN must be at least 1");
      end
      if (LVL_W < 1 || LVL_W > 8) begin : g_bad_level
         $error("grp_chain_arbiter: LVL_W must lie in 1..8");
      end
      if (GRP_W != idx_width(NUM_GROUPS)) begin : g_bad_grp_w
         $error("grp_chain_arbiter: group index width mismatch");
      end
   endgenerate

   // central parallel stage
   logic [NUM_GROUPS-1:0] grp_req;
   logic [NUM_GROUPS-1:0] grp_gnt;
   logic                  any_elig;

   arb_group_pick #(
      .NG    (NUM_GROUPS),
      .LVL_W (LVL_W)
   ) u_pick (
      .greq_i  (grp_req),
      .level_i (cpu_level_i),
      .ggnt_o  (grp_gnt),
      .any_o   (any_elig)
   );

   // one daisy chain per group
   logic [NUM_MASTERS-1:0] cand;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chain
         arb_daisy_chain #(
            .LEN       (CHAIN_LEN),
            .LOOKAHEAD (CHAIN_LOOKAHEAD)
         ) u_chain (
            .req_i  (req_i[g*CHAIN_LEN +: CHAIN_LEN]),
            .gin_i  (grp_gnt[g]),
            .gnt_o  (cand[g*CHAIN_LEN +: CHAIN_LEN]),
            .greq_o (grp_req[g])
         );
      end
   endgenerate

   // winner indices
   logic [CHAIN_LEN-1:0] pos_oh;
   logic [GRP_W-1:0]     cand_group;
   logic [POS_W-1:0]     cand_pos;

   always_comb begin
      pos_oh = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         pos_oh = pos_oh | cand[g*CHAIN_LEN +: CHAIN_LEN];
      end
   end

   arb_onehot_enc #(.N(NUM_GROUPS), .W(GRP_W)) u_enc_grp (
      .oh_i  (grp_gnt),
      .idx_o (cand_group)
   );

   arb_onehot_enc #(.N(CHAIN_LEN), .W(POS_W)) u_enc_pos (
      .oh_i  (pos_oh),
      .idx_o (cand_pos)
   );

   // offer / ownership sequencing
   arb_state_e             state_q;
   logic [NUM_MASTERS-1:0] grant_q;
   logic [GRP_W-1:0]       group_q;
   logic [POS_W-1:0]       pos_q;
   logic                   granted_req;

   assign granted_req = |(grant_q & req_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         grant_q <= '0;
         group_q <= '0;
         pos_q   <= '0;
      end else begin
         unique case (state_q)
            ARB_IDLE: begin
               if (!bus_busy_i && any_elig) begin
                  state_q <= ARB_OFFER;
                  grant_q <= cand;
                  group_q <= cand_group;
                  pos_q   <= cand_pos;
               end
            end
            ARB_OFFER: begin
               if (bus_busy_i) begin
                  state_q <= ARB_OWNED;
                  grant_q <= '0;
                  group_q <= '0;
                  pos_q   <= '0;
               end else if (!granted_req) begin
                  state_q <= ARB_IDLE;
                  grant_q <= '0;
                  group_q <= '0;
                  pos_q   <= '0;
               end
            end
            ARB_OWNED: begin
               if (!bus_busy_i) state_q <= ARB_IDLE;
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign grant_o       = grant_q;
   assign grant_valid_o = (state_q == ARB_OFFER);
   assign win_group_o   = group_q;
   assign win_pos_o     = pos_q;

   // assertions
   p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

   p_issue_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid_o) |-> $past(!bus_busy_i));

   p_level_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid_o) |-> (int'(win_group_o) > int'($past(cpu_level_i))));

   p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && !bus_busy_i && granted_req) |=> (grant_valid_o && $stable(grant_o)));

   p_drop_on_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && bus_busy_i) |=> !grant_valid_o);

   p_no_grant_while_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ARB_OWNED) |=> !grant_valid_o);

   p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && !bus_busy_i && !granted_req) |=> !grant_valid_o);

   p_idx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid_o |-> (win_group_o == '0 && win_pos_o == '0));

endmodule

// File: tb/grp_chain_arbiter_test.sv
module grp_chain_arbiter_test;

   localparam int NG = 5;
   localparam int L  = 4;
   localparam int NM = NG * L;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NM-1:0] req;
   logic          busy;
   logic [2:0]    lvl;
   logic [NM-1:0] grant_o;
   logic          grant_valid_o;
   logic [2:0]    win_group_o;
   logic [1:0]    win_pos_o;

   int    checks = 0;
   int    failures = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   always #4 clk = ~clk;

   grp_chain_arbiter uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req),
      .bus_busy_i    (busy),
      .cpu_level_i   (lvl),
      .grant_o       (grant_o),
      .grant_valid_o (grant_valid_o),
      .win_group_o   (win_group_o),
      .win_pos_o     (win_pos_o)
   );

   function automatic logic [NM-1:0] mb(input int g, input int p);
      logic [NM-1:0] v;
      v = '0;
      v[g*L+p] = 1'b1;
      return v;
   endfunction

   function automatic int pick(input logic [NM-1:0] r, input logic [2:0] l);
      for (int g = NG - 1; g >= 0; g--) begin
         if (g > int'(l)) begin
            for (int p = 0; p < L; p++) begin
               if (r[g*L+p]) return g*L + p;
            end
         end
      end
      return -1;
   endfunction

   // behavioural reference: 0 idle, 1 offer, 2 owned
   int m_state;
   int m_idx;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 0;
         m_idx   <= 0;
      end else begin
         case (m_state)
            0: if (!busy && pick(req, lvl) >= 0) begin
                  m_state <= 1;
                  m_idx   <= pick(req, lvl);
               end
            1: if (busy) m_state <= 2;
               else if (!req[m_idx]) m_state <= 0;
            default: if (!busy) m_state <= 0;
         endcase
      end
   end

   always @(negedge clk) begin
      logic [NM-1:0] e_gnt;
      int e_grp, e_pos;
      e_gnt = '0;
      e_grp = 0;
      e_pos = 0;
      if (m_state == 1) begin
         e_gnt[m_idx] = 1'b1;
         e_grp = m_idx / L;
         e_pos = m_idx % L;
      end
      checks++;
      if (grant_o !== e_gnt || grant_valid_o !== (m_state == 1) ||
          int'(win_group_o) != e_grp || int'(win_pos_o) != e_pos) begin
         failures++;
         $display("FAIL %s cycle %0d: grant=%h valid=%b grp=%0d pos=%0d expected grant=%h valid=%b grp=%0d pos=%0d",
                  cur_tag, cyc, grant_o, grant_valid_o, win_group_o, win_pos_o,
                  e_gnt, (m_state == 1), e_grp, e_pos);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic [NM-1:0] r, input logic b, input logic [2:0] l,
                       input int n, input string tag);
      cur_tag = tag;
      req  = r;
      busy = b;
      lvl  = l;
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 5000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      req   = '1;
      busy  = 1'b0;
      lvl   = 3'd0;
      // R1: reset dominates requests
      step('1, 1'b0, 3'd0, 3, "R1");
      chk("R1 valid in reset", int'(grant_valid_o), 0);
      chk("R1 grant in reset", int'(grant_o != '0), 0);
      req = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;

      // R2: higher group wins, then ownership cycle (R6)
      step(mb(2, 0) | mb(3, 3), 1'b0, 3'd0, 2, "R2");
      chk("R2 winning group", int'(win_group_o), 3);
      chk("R2 winning pos", int'(win_pos_o), 3);
      step(mb(2, 0) | mb(3, 3), 1'b1, 3'd0, 1, "R6");
      chk("R6 grant drops on busy", int'(grant_valid_o), 0);
      step(mb(2, 0), 1'b1, 3'd0, 2, "R6");
      chk("R6 no grant while owned", int'(grant_valid_o), 0);
      step(mb(2, 0), 1'b0, 3'd0, 1, "R6");
      chk("R6 no grant at busy-fall edge", int'(grant_valid_o), 0);
      step(mb(2, 0), 1'b0, 3'd0, 1, "R6");
      chk("R6 waiting master granted", int'(grant_o == mb(2, 0)), 1);
      // busy rises while request drops: busy wins
      step(mb(1, 1), 1'b1, 3'd0, 1, "R6");
      step(mb(1, 1), 1'b1, 3'd0, 2, "R6");
      chk("R6 owned after busy with drop", int'(grant_valid_o), 0);
      step(mb(1, 1), 1'b0, 3'd0, 1, "R6");
      chk("R6 owned exit no grant", int'(grant_valid_o), 0);
      step(mb(1, 1), 1'b0, 3'd0, 1, "R6");
      chk("R6 grant after release", int'(win_group_o), 1);
      step('0, 1'b0, 3'd0, 2, "R6");

      // R3: chain position
      step(mb(4, 1) | mb(4, 2) | mb(4, 3), 1'b0, 3'd0, 2, "R3");
      chk("R3 nearest requester", int'(grant_o == mb(4, 1)), 1);
      step('0, 1'b0, 3'd0, 2, "R3");

      // R7: withdrawal
      step(mb(3, 1) | mb(1, 0), 1'b0, 3'd0, 1, "R7");
      chk("R7 offered", int'(win_group_o), 3);
      step(mb(1, 0), 1'b0, 3'd0, 1, "R7");
      chk("R7 withdrawn", int'(grant_valid_o), 0);
      step(mb(1, 0), 1'b0, 3'd0, 1, "R7");
      chk("R7 next requester", int'(grant_o == mb(1, 0)), 1);
      step('0, 1'b0, 3'd0, 2, "R7");

      // R4: level mask
      step(mb(3, 0) | mb(2, 1) | mb(0, 0), 1'b0, 3'd3, 3, "R4");
      chk("R4 masked at level 3", int'(grant_valid_o), 0);
      step(mb(3, 0) | mb(4, 2), 1'b0, 3'd3, 2, "R4");
      chk("R4 group above level", int'(grant_o == mb(4, 2)), 1);
      step('0, 1'b0, 3'd3, 2, "R4");
      step('1, 1'b0, 3'd7, 3, "R4");
      chk("R4 level 7 blocks all", int'(grant_valid_o), 0);
      step(mb(0, 0) | mb(0, 3), 1'b0, 3'd0, 3, "R4");
      chk("R4 group 0 never", int'(grant_valid_o), 0);
      step(mb(3, 3), 1'b0, 3'd2, 2, "R4");
      chk("R4 level 2 allows 3", int'(win_group_o), 3);
      step('0, 1'b0, 3'd0, 2, "R4");

      // R5: busy held by another owner
      step(mb(4, 0), 1'b1, 3'd0, 4, "R5");
      chk("R5 no grant while busy", int'(grant_valid_o), 0);
      step(mb(4, 0), 1'b0, 3'd0, 1, "R5");
      chk("R5 grant once idle", int'(grant_valid_o), 1);
      step('0, 1'b0, 3'd0, 2, "R5");

      // R8: indices
      step(mb(1, 3), 1'b0, 3'd0, 2, "R8");
      chk("R8 one-hot grant", int'(grant_o == mb(1, 3)), 1);
      chk("R8 group index", int'(win_group_o), 1);
      chk("R8 pos index", int'(win_pos_o), 3);
      step('0, 1'b0, 3'd0, 2, "R8");
      chk("R8 idle indices", int'(win_group_o) + int'(win_pos_o), 0);

      // R9: far member makes its group compete
      step(mb(4, 3) | mb(3, 0), 1'b0, 3'd0, 2, "R9");
      chk("R9 group", int'(win_group_o), 4);
      chk("R9 pos", int'(win_pos_o), 3);
      step('0, 1'b0, 3'd0, 3, "R9");

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule